// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block receives packets from a low-speed USB pair. The D+ and D- lines are sampled by a clock that runs at eight times the bit rate: 12 MHz against 1.5 Mbit/s, so one bit lasts 8 clocks. The block passes the lines through a synchronizer. It then hunts for the sync field, using each J-to-K edge to set its sampling phase to mid-bit. Sync is taken as finished when two K bits arrive in a row. After that the block NRZI-decodes the line, drops stuffed bits and packs the result into bytes, least significant bit first.

Each completed byte is presented for one cycle with a strobe. The block counts each byte against a fixed byte budget. A single-ended zero (SE0) ends the packet, and the block then reports how many bytes it stored. A packet that exceeds the budget is aborted with an overflow pulse. While idle, the block pulses a frame-timeout output whenever no K edge appears within a set window.

The controller has four states:
- `ST_IDLE_J` waits for J. It moves to `ST_HUNT_K` when it sees J.
- `ST_HUNT_K` waits for K. When K appears it moves to `ST_SYNC_END`. If the window runs out first, it pulses the timeout and returns to `ST_IDLE_J`.
- `ST_SYNC_END` samples one and a half bits after the edge. A K there moves it to `ST_DATA`. Anything else sends it back to `ST_HUNT_K`.
- `ST_DATA` decodes bits. It returns to `ST_IDLE_J` on an end of packet or on an overflow.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is held and right after it, `byte_valid`, `eop_valid`, `overflow` and `frame_timeout` are all 0. At most one of these four is high in any cycle.
- R2: Line states are J = {dp,dm} = 01, K = 10 and SE0 = 00. The line pattern K,J,K,J,K,J,K,K is a sync field. Data decoding begins with the bit that follows its final K.
- R3: When a J-to-K edge is followed one bit later by J, the receiver keeps hunting. Any number of extra K,J pairs before the closing K,K still gives correct reception, and a lone K pulse produces no packet.
- R4: An NRZI bit is 1 when the D- level is unchanged from the previous bit and 0 when it changes. The first data bit is compared against the closing K of sync. Bytes are assembled LSB first, and each is presented on `byte_data` with a one-cycle `byte_valid`.
- R5: After six consecutive decoded 1s, the next bit is a stuffed bit and is discarded. The closing 1 of the sync field counts toward those six.
- R6: SE0 sampled at the second or any later bit position of a byte ends the packet. `eop_valid` pulses with `eop_count` equal to the number of bytes delivered, and any partial byte is discarded.
- R7: SE0 sampled at the first bit position of a byte does not end the packet. That bit is decoded from the D- level alone, so SE0 there acts as K.
- R8: With a budget of MAX_BYTES (default 11), bytes beyond the budget are not delivered. The byte that would exceed it pulses `overflow` instead of `byte_valid`. No `eop_valid` follows for that packet, and the receiver returns to the idle search.
- R9: With the line idle at J, `frame_timeout` pulses once every TIMEOUT_CLKS+1 cycles (default 65).
- R10: After an end of packet the receiver returns to the idle search, and a packet that starts right after the J following the EOP is received in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 8x bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp | input | 1 | D+ line level |
| dm | input | 1 | D- line level |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte, valid with `byte_valid` |
| eop_valid | output | 1 | One-cycle end-of-packet strobe |
| eop_count | output | $clog2(MAX_BYTES+1) | Bytes delivered in the packet, valid with `eop_valid` |
| overflow | output | 1 | One-cycle abort strobe for an over-budget packet |
| frame_timeout | output | 1 | One-cycle pulse when no K edge arrives in time |

## Verification
The bench sends a first byte of 0x1F, which checks that the closing 1 of sync counts toward the stuffing run. A receiver that restarts the run at zero would keep a stuffed bit and shift every following byte. The bench also drives SE0 in place of a K at the first bit of a mid-packet byte. A receiver that trusts SE0 there would end the packet early with too small a count.

A further test adds three extra bits before the EOP, which must be discarded. Another sends exactly one byte over budget: a design that gets the budget wrong delivers a twelfth byte or still reports an EOP. The bench also sends extra K,J pairs and a lone K pulse, which would catch a receiver that locks onto the first edge. Finally it sends a packet right after another one's EOP, which would catch a receiver that stays stuck after an end of packet.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE_J,
        ST_HUNT_K,
        ST_SYNC_END,
        ST_DATA
    } rx_state_e;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned STUFF_RUN = 6;

    // {dp, dm} encodings
    localparam logic [1:0] LINE_J   = 2'b01;
    localparam logic [1:0] LINE_K   = 2'b10;
    localparam logic [1:0] LINE_SE0 = 2'b00;

endpackage

// File: rtl/usbrx_line_in.sv
module usbrx_line_in
    import usbrx_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dp,
    input  logic dm,
    output logic is_j,
    output logic is_k,
    output logic is_se0,
    output logic level
);

    logic [1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= LINE_J;
                else        chain_q[0] <= {dp, dm};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= LINE_J;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign is_j   = (chain_q[STAGES-1] == LINE_J);
    assign is_k   = (chain_q[STAGES-1] == LINE_K);
    assign is_se0 = (chain_q[STAGES-1] == LINE_SE0);
    assign level  = chain_q[STAGES-1][0];

    a_r2_line_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_j, is_k, is_se0}));

endmodule

// File: rtl/usbrx_nrzi_unstuff.sv
module usbrx_nrzi_unstuff
    import usbrx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic sample,
    input  logic level,
    output logic bit_ok,
    output logic bit_val
);

    localparam logic [2:0] RUN_MAX = 3'(STUFF_RUN);

    logic       prev_q;
    logic [2:0] ones_q;
    logic       stuffed;

    assign stuffed = (ones_q == RUN_MAX);
    assign bit_val = (level == prev_q);
    assign bit_ok  = sample && !stuffed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            ones_q <= 3'd0;
        end else if (init) begin
            prev_q <= 1'b0;      // closing K of sync: D- low
            ones_q <= 3'd1;      // closing sync bit decodes as 1
        end else if (sample) begin
            prev_q <= level;
            if (stuffed)      ones_q <= 3'd0;
            else if (bit_val) ones_q <= ones_q + 3'd1;
            else              ones_q <= 3'd0;
        end
    end

    a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= RUN_MAX);

endmodule

// File: rtl/usbrx_byte_pack.sv
module usbrx_byte_pack
    import usbrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              bit_ok,
    input  logic              bit_val,
    output logic              byte_full,
    output logic [BYTE_W-1:0] byte_next,
    output logic [2:0]        bitpos
);

    logic [BYTE_W-1:0] sr_q;
    logic [2:0]        pos_q;

    assign byte_next = {bit_val, sr_q[BYTE_W-1:1]};
    assign byte_full = bit_ok && (pos_q == 3'(BYTE_W - 1));
    assign bitpos    = pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            pos_q <= 3'd0;
        end else if (init) begin
            sr_q  <= '0;
            pos_q <= 3'd0;
        end else if (bit_ok) begin
            sr_q  <= byte_next;
            pos_q <= pos_q + 3'd1;
        end
    end

    a_r4_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !bit_ok) |=> $stable(pos_q));

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usbrx_pkg::*;
#(
    parameter int unsigned BIT_CLKS     = 8,
    parameter int unsigned MAX_BYTES    = 11,
    parameter int unsigned TIMEOUT_CLKS = 64,
    parameter int unsigned SYNC_STAGES  = 2,
    localparam int unsigned CW          = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp,
    input  logic              dm,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              eop_valid,
    output logic [CW-1:0]     eop_count,
    output logic              overflow,
    output logic              frame_timeout
);

    localparam int unsigned HALF = BIT_CLKS / 2;
    localparam int unsigned CNTW = $clog2(TIMEOUT_CLKS + 2 * BIT_CLKS + 1);
    localparam logic [CNTW-1:0] BIT_LAST  = CNTW'(BIT_CLKS - 1);
    localparam logic [CNTW-1:0] SYNC_LAST = CNTW'(BIT_CLKS + HALF - 1);
    localparam logic [CNTW-1:0] TO_LAST   = CNTW'(TIMEOUT_CLKS - 1);
    localparam logic [CW-1:0]   BUDGET    = CW'(MAX_BYTES);

    rx_state_e state_q, state_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic [CW-1:0]   rem_q, rem_d, stored_q, stored_d;

    logic ln_j, ln_k, ln_se0, ln_level;
    logic tick, se0_end, dec_sample, init;
    logic bit_ok, bit_val, byte_full;
    logic [BYTE_W-1:0] byte_next;
    logic [2:0] bitpos;

    logic bv_d, eop_d, ovf_d, to_d;

    usbrx_line_in #(.STAGES(SYNC_STAGES)) u_line (
        .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm),
        .is_j(ln_j), .is_k(ln_k), .is_se0(ln_se0), .level(ln_level)
    );

    assign tick       = (state_q == ST_DATA) && (cnt_q == BIT_LAST);
    assign se0_end    = tick && ln_se0 && (bitpos != 3'd0);
    assign dec_sample = tick && !se0_end;

    usbrx_nrzi_unstuff u_dec (
        .clk(clk), .rst_n(rst_n), .init(init), .sample(dec_sample),
        .level(ln_level), .bit_ok(bit_ok), .bit_val(bit_val)
    );

    usbrx_byte_pack u_pack (
        .clk(clk), .rst_n(rst_n), .init(init), .bit_ok(bit_ok),
        .bit_val(bit_val), .byte_full(byte_full), .byte_next(byte_next),
        .bitpos(bitpos)
    );

    // next-state and event decode
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q + 1'b1;
        rem_d    = rem_q;
        stored_d = stored_q;
        init     = 1'b0;
        bv_d     = 1'b0;
        eop_d    = 1'b0;
        ovf_d    = 1'b0;
        to_d     = 1'b0;
        unique case (state_q)
            ST_IDLE_J: begin
                cnt_d = '0;
                if (ln_j) state_d = ST_HUNT_K;
            end
            ST_HUNT_K: begin
                if (ln_k) begin
                    state_d = ST_SYNC_END;
                    cnt_d   = '0;
                end else if (cnt_q == TO_LAST) begin
                    to_d    = 1'b1;
                    state_d = ST_IDLE_J;
                    cnt_d   = '0;
                end
            end
            ST_SYNC_END: begin
                if (cnt_q == SYNC_LAST) begin
                    cnt_d = '0;
                    if (ln_k) begin
                        state_d  = ST_DATA;
                        init     = 1'b1;
                        rem_d    = BUDGET;
                        stored_d = '0;
                    end else begin
                        state_d = ST_HUNT_K;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    cnt_d = '0;
                    if (se0_end) begin
                        eop_d   = 1'b1;
                        state_d = ST_IDLE_J;
                    end else if (byte_full) begin
                        if (rem_q == '0) begin
                            ovf_d   = 1'b1;
                            state_d = ST_IDLE_J;
                        end else begin
                            bv_d     = 1'b1;
                            rem_d    = rem_q - 1'b1;
                            stored_d = stored_q + 1'b1;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE_J;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE_J;
            cnt_q    <= '0;
            rem_q    <= '0;
            stored_q <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            rem_q    <= rem_d;
            stored_q <= stored_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            eop_valid     <= 1'b0;
            eop_count     <= '0;
            overflow      <= 1'b0;
            frame_timeout <= 1'b0;
        end else begin
            byte_valid    <= bv_d;
            eop_valid     <= eop_d;
            overflow      <= ovf_d;
            frame_timeout <= to_d;
            if (bv_d)  byte_data <= byte_next;
            if (eop_d) eop_count <= stored_q;
        end
    end

    a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_valid, eop_valid, overflow, frame_timeout}));

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        eop_valid |-> (eop_count <= BUDGET));

    a_r8_quiet_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (!byte_valid && !eop_valid));

    a_r9_timeout_from_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        frame_timeout |-> (state_q == ST_IDLE_J));

endmodule

// File: tb/usb_ls_rx_bench.sv
module usb_ls_rx_bench;

    localparam int BIT = 8;
    localparam int MAXB = 11;
    localparam int TO = 64;
    localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp = 1'b0, dm = 1'b1;
    logic byte_valid, eop_valid, overflow, frame_timeout;
    logic [7:0] byte_data;
    logic [3:0] eop_count;

    always #4 clk = ~clk;

    usb_ls_rx u_usb_ls_rx (
        .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .eop_valid(eop_valid), .eop_count(eop_count),
        .overflow(overflow), .frame_timeout(frame_timeout)
    );

    int checks = 0, fails = 0;
    logic [7:0] rx_bytes [32];
    int rx_n = 0, eop_n = 0, eop_last = 0, ovf_n = 0, to_n = 0, multi_n = 0;
    logic [7:0] pkt [16];
    int cyc = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (byte_valid) begin
            if (rx_n < 32) rx_bytes[rx_n] = byte_data;
            rx_n++;
        end
        if (eop_valid) begin eop_n++; eop_last = int'(eop_count); end
        if (overflow) ovf_n++;
        if (frame_timeout) to_n++;
        if (rst_n && (int'(byte_valid) + int'(eop_valid) + int'(overflow) + int'(frame_timeout) > 1))
            multi_n++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        rx_n = 0; eop_n = 0; ovf_n = 0; to_n = 0;
    endtask

    task automatic drive(input logic [1:0] ln, input int bits);
        for (int i = 0; i < bits * BIT; i++) begin
            @(negedge clk);
            {dp, dm} = ln;
        end
    endtask

    // sends sync (with extra K,J pairs), NRZI/stuffed data, extra zero bits, EOP
    task automatic tx_packet(input int n, input int se0_byte, input int extra_pairs,
                             input int extra_bits);
        int ones;
        logic cur_k;
        logic b;
        for (int p = 0; p < extra_pairs; p++) begin drive(LK, 1); drive(LJ, 1); end
        drive(LK, 1); drive(LJ, 1); drive(LK, 1); drive(LJ, 1);
        drive(LK, 1); drive(LJ, 1); drive(LK, 1); drive(LK, 1);
        cur_k = 1'b1;
        ones = 1;
        for (int i = 0; i < n + 1; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (i == n && j >= extra_bits) break;
                b = (i < n) ? pkt[i][j] : 1'b0;
                if (i == se0_byte && j == 0) begin
                    b = cur_k;
                    pkt[i][0] = b;
                end
                if (!b) cur_k = ~cur_k;
                if (i == se0_byte && j == 0) drive(LSE0, 1);
                else drive(cur_k ? LK : LJ, 1);
                ones = b ? ones + 1 : 0;
                if (ones == 6) begin
                    cur_k = ~cur_k;
                    drive(cur_k ? LK : LJ, 1);
                    ones = 0;
                end
            end
        end
        drive(LSE0, 2);
        drive(LJ, 1);
    endtask

    task automatic expect_pkt(input int n, input string tag);
        drive(LJ, 3);
        chk(rx_n == n, {tag, " byte count"}, rx_n, n);
        for (int i = 0; i < n && i < rx_n; i++)
            chk(rx_bytes[i] == pkt[i], {tag, " byte value"}, int'(rx_bytes[i]), int'(pkt[i]));
        chk(eop_n == 1, {tag, " eop strobe"}, eop_n, 1);
        chk(eop_last == n, {tag, " eop_count"}, eop_last, n);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(!byte_valid && !eop_valid && !overflow && !frame_timeout, "R1 outputs in reset",
            int'({byte_valid, eop_valid, overflow, frame_timeout}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!byte_valid && !eop_valid && !overflow && !frame_timeout, "R1 outputs after reset",
            int'({byte_valid, eop_valid, overflow, frame_timeout}), 0);
    endtask

    task automatic t_basic();   // R2 R4 R6
        drive(LJ, 4); clr_mon();
        pkt[0] = 8'h2D; pkt[1] = 8'hA5; pkt[2] = 8'h00;
        tx_packet(3, -1, 0, 0);
        expect_pkt(3, "R2/R4 basic");
    endtask

    task automatic t_stuff();   // R5
        drive(LJ, 4); clr_mon();
        pkt[0] = 8'h1F; pkt[1] = 8'hFF; pkt[2] = 8'hFF; pkt[3] = 8'h7E;
        tx_packet(4, -1, 0, 0);
        expect_pkt(4, "R5 stuffing");
    endtask

    task automatic t_false_sync();  // R3
        drive(LJ, 4); clr_mon();
        drive(LK, 1); drive(LJ, 8);
        chk(rx_n == 0 && eop_n == 0, "R3 lone K no packet", rx_n + eop_n, 0);
        clr_mon();
        pkt[0] = 8'h69; pkt[1] = 8'h3C;
        tx_packet(2, -1, 3, 0);
        expect_pkt(2, "R3 long preamble");
    endtask

    task automatic t_partial();  // R6
        drive(LJ, 4); clr_mon();
        pkt[0] = 8'hC3; pkt[1] = 8'h18;
        tx_packet(2, -1, 0, 3);
        expect_pkt(2, "R6 partial dropped");
    endtask

    task automatic t_se0_first();  // R7
        drive(LJ, 4); clr_mon();
        pkt[0] = 8'h4B; pkt[1] = 8'h96; pkt[2] = 8'h5A;
        tx_packet(3, 1, 0, 0);
        expect_pkt(3, "R7 SE0 at bit0");
    endtask

    task automatic t_overflow();  // R8
        drive(LJ, 4); clr_mon();
        for (int i = 0; i < MAXB + 1; i++) pkt[i] = 8'(8'h11 * i + 3);
        tx_packet(MAXB + 1, -1, 0, 0);
        drive(LJ, 3);
        chk(rx_n == MAXB, "R8 bytes delivered", rx_n, MAXB);
        chk(ovf_n == 1, "R8 overflow pulse", ovf_n, 1);
        chk(eop_n == 0, "R8 no eop", eop_n, 0);
        chk(rx_n > 0 && rx_bytes[MAXB - 1] == pkt[MAXB - 1], "R8 last stored byte",
            int'(rx_bytes[MAXB - 1]), int'(pkt[MAXB - 1]));
    endtask

    task automatic t_timeout();  // R9
        drive(LJ, 30);
        to_n = 0;
        for (int i = 0; i < 10 * (TO + 1); i++) @(negedge clk);
        chk(to_n == 10, "R9 timeout rate", to_n, 10);
    endtask

    task automatic t_back_to_back();  // R10
        drive(LJ, 4); clr_mon();
        pkt[0] = 8'hE1; pkt[1] = 8'h07;
        tx_packet(2, -1, 0, 0);
        chk(eop_n == 1, "R10 first eop", eop_n, 1);
        clr_mon();
        pkt[0] = 8'hD2; pkt[1] = 8'h80; pkt[2] = 8'h01;
        tx_packet(3, -1, 0, 0);
        expect_pkt(3, "R10 second packet");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_stuff();
        t_false_sync();
        t_partial();
        t_se0_first();
        t_overflow();
        t_timeout();
        t_back_to_back();
        chk(multi_n == 0, "R1 one event per cycle", multi_n, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule